// File: doc/BRIEF.md
# Cartridge Expansion Port Address Decoder

This block sits between a CPU's address bus and the cartridge expansion port of an 8-bit home computer. For every access it checks whether the address belongs to the plugged-in cartridge or to internal memory. For a cartridge access it also names the one port strobe to assert: the low ROM window strobe, the high ROM window strobe, or one of the two 256-byte IO page strobes.

The cartridge reports its configuration on two active-low lines, `exrom_n` and `game_n`. Four configurations follow from them: no cartridge, 8 KB, 16 KB and the "ultimax" layout, in which the high ROM moves to the top of the address space. An internal sector-buffer overlay can be mapped over the IO pages. While it is mapped, the overlay wins and those accesses stay internal.

Decisions are registered. Each output reflects the inputs sampled on the previous rising clock edge. This gives the chip-select logic a full cycle of timing.

Top module: `cartport_decoder`

## Requirements
- R1: While `rst` is high, and on the first edge after it, every output is low.
- R2: Outputs change only on a rising clock edge, one cycle after the inputs that caused them are sampled.
- R3: When `acc_valid` is low, every output is low after the next edge, including `int_sel`.
- R4: With `exrom_n`=1 and `game_n`=1, no cartridge is present. Every valid access asserts `int_sel` only, including $DE00-$DFFF.
- R5: With `exrom_n`=0 and `game_n`=1 (8 KB), addresses $8000-$9FFF assert `roml` and `cart_sel`. $A000-$BFFF and $E000-$FFFF stay internal.
- R6: With `exrom_n`=0 and `game_n`=0 (16 KB), $8000-$9FFF asserts `roml` and $A000-$BFFF asserts `romh`. $C000-$FFFF stays internal.
- R7: With `exrom_n`=1 and `game_n`=0 (ultimax), $8000-$9FFF asserts `roml` and $E000-$FFFF asserts `romh`. $A000-$BFFF stays internal.
- R8: With any cartridge present and `ovl_map` low, $DE00-$DEFF asserts `io1` and $DF00-$DFFF asserts `io2`, each with `cart_sel`.
- R9: With `ovl_map` high, $DE00-$DFFF goes internal and `io1` and `io2` stay low. ROM windows are unaffected.
- R10: At most one of `roml`, `romh`, `io1`, `io2` is high. `cart_sel` is high exactly when one of them is. For a valid access, `int_sel` is the inverse of `cart_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| acc_valid | input | 1 | An access is presented this cycle |
| addr | input | 16 | CPU address |
| exrom_n | input | 1 | Cartridge configuration line, active low |
| game_n | input | 1 | Cartridge configuration line, active low |
| ovl_map | input | 1 | Internal sector buffer mapped over the IO pages |
| cart_sel | output | 1 | Access goes to the expansion port |
| int_sel | output | 1 | Access goes to internal memory |
| roml | output | 1 | Low ROM window strobe |
| romh | output | 1 | High ROM window strobe |
| io1 | output | 1 | First IO page strobe ($DExx) |
| io2 | output | 1 | Second IO page strobe ($DFxx) |

## Verification
The bench probes each window at its first and last byte and one byte outside it. An off-by-one boundary would then show as a missing or stray strobe at $7FFF, $9FFF, $BFFF or $DDFF.

The bench runs the same addresses in all four configurations. A design that mixed up the ultimax and 16 KB layouts would put `romh` at the wrong base. A design that kept IO routed with no cartridge would drive `io1` with both lines high.

With the overlay mapped, the bench expects internal selection at $DE00 and $DF80, together with an unchanged ROM window. A design that gave the port priority over the overlay would fight the sector buffer.

A sample taken before the clock edge catches a decoder that responds combinationally rather than one cycle later.

// File: rtl/cartport_pkg.sv
package cartport_pkg;

    typedef struct packed {
        logic present;
        logic lo_en;
        logic hi_mid_en;
        logic hi_top_en;
    } cart_mode_t;

    typedef struct packed {
        logic lo;
        logic hi_mid;
        logic hi_top;
        logic iop1;
        logic iop2;
    } addr_hit_t;

    typedef struct packed {
        logic cart;
        logic intl;
        logic roml;
        logic romh;
        logic io1;
        logic io2;
    } dec_out_t;

endpackage

// File: rtl/cart_mode_decode.sv
module cart_mode_decode
    import cartport_pkg::*;
(
    input  logic       exrom_n,
    input  logic       game_n,
    output cart_mode_t mode
);
    always_comb begin
        mode = '0;
        unique case ({exrom_n, game_n})
            2'b11: mode = '0;                                        // absent
            2'b01: mode = '{present:1'b1, lo_en:1'b1, default:1'b0}; // 8 KB
            2'b00: mode = '{present:1'b1, lo_en:1'b1, hi_mid_en:1'b1, hi_top_en:1'b0};
            2'b10: mode = '{present:1'b1, lo_en:1'b1, hi_mid_en:1'b0, hi_top_en:1'b1};
            default: mode = '0;
        endcase
    end
endmodule

// File: rtl/cart_window_match.sv
module cart_window_match
    import cartport_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output addr_hit_t         hit
);
    localparam int SEG_W  = 3;
    localparam int PAGE_W = ADDR_W - 8;
    localparam logic [SEG_W-1:0]  SEG_LO   = SEG_W'(4);
    localparam logic [SEG_W-1:0]  SEG_MID  = SEG_W'(5);
    localparam logic [SEG_W-1:0]  SEG_TOP  = SEG_W'(7);
    localparam logic [PAGE_W-1:0] PAGE_IO1 = PAGE_W'(8'hDE);
    localparam logic [PAGE_W-1:0] PAGE_IO2 = PAGE_W'(8'hDF);

    logic [SEG_W-1:0]  seg;
    logic [PAGE_W-1:0] page;

    always_comb begin
        seg        = addr[ADDR_W-1 -: SEG_W];
        page       = addr[ADDR_W-1 -: PAGE_W];
        hit.lo     = (seg == SEG_LO);
        hit.hi_mid = (seg == SEG_MID);
        hit.hi_top = (seg == SEG_TOP);
        hit.iop1   = (page == PAGE_IO1);
        hit.iop2   = (page == PAGE_IO2);
    end
endmodule

// File: rtl/cartport_decoder.sv
module cartport_decoder
    import cartport_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] addr,
    input  logic              exrom_n,
    input  logic              game_n,
    input  logic              ovl_map,
    output logic              cart_sel,
    output logic              int_sel,
    output logic              roml,
    output logic              romh,
    output logic              io1,
    output logic              io2
);
    cart_mode_t mode;
    addr_hit_t  hit;
    dec_out_t   dec_d, dec_q;

    cart_mode_decode u_mode (
        .exrom_n (exrom_n),
        .game_n  (game_n),
        .mode    (mode)
    );

    cart_window_match #(.ADDR_W(ADDR_W)) u_match (
        .addr (addr),
        .hit  (hit)
    );

    always_comb begin
        dec_d = '0;
        if (acc_valid) begin
            dec_d.roml = mode.lo_en && hit.lo;
            dec_d.romh = (mode.hi_mid_en && hit.hi_mid) || (mode.hi_top_en && hit.hi_top);
            dec_d.io1  = mode.present && !ovl_map && hit.iop1;
            dec_d.io2  = mode.present && !ovl_map && hit.iop2;
            dec_d.cart = dec_d.roml || dec_d.romh || dec_d.io1 || dec_d.io2;
            dec_d.intl = !dec_d.cart;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) dec_q <= '0;
        else     dec_q <= dec_d;
    end

    assign cart_sel = dec_q.cart;
    assign int_sel  = dec_q.intl;
    assign roml     = dec_q.roml;
    assign romh     = dec_q.romh;
    assign io1      = dec_q.io1;
    assign io2      = dec_q.io2;

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({roml, romh, io1, io2}) && (cart_sel == ($countones({roml, romh, io1, io2}) == 1))); // R10
    AST_OVERLAY_WINS: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && ovl_map) |=> (!io1 && !io2)); // R9
    AST_ABSENT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (exrom_n && game_n) |=> !cart_sel); // R4
    AST_IDLE_NO_ACC: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> !(cart_sel || int_sel)); // R3
    AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> (cart_sel != int_sel)); // R10
endmodule

// File: tb/cartport_decoder_tb.sv
module cartport_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        acc_valid;
    logic [15:0] addr;
    logic        exrom_n, game_n, ovl_map;
    logic        cart_sel, int_sel, roml, romh, io1, io2;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    cartport_decoder #(.ADDR_W(16)) dut_i (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .addr(addr),
        .exrom_n(exrom_n), .game_n(game_n), .ovl_map(ovl_map),
        .cart_sel(cart_sel), .int_sel(int_sel), .roml(roml), .romh(romh),
        .io1(io1), .io2(io2)
    );

    // {addr, exrom_n, game_n, ovl_map, acc_valid, exp{cart,int,roml,romh,io1,io2}}
    localparam int NV = 24;
    localparam logic [25:0] VEC [NV] = '{
        {16'h8000, 4'b1101, 6'b010000}, // R4
        {16'hDE00, 4'b1101, 6'b010000}, // R4
        {16'hE000, 4'b1101, 6'b010000}, // R4
        {16'h8000, 4'b0101, 6'b101000}, // R5
        {16'h9FFF, 4'b0101, 6'b101000}, // R5
        {16'hA000, 4'b0101, 6'b010000}, // R5
        {16'h7FFF, 4'b0101, 6'b010000}, // R5
        {16'hDE10, 4'b0101, 6'b100010}, // R8
        {16'hDFFF, 4'b0101, 6'b100001}, // R8
        {16'h9000, 4'b0001, 6'b101000}, // R6
        {16'hA000, 4'b0001, 6'b100100}, // R6
        {16'hBFFF, 4'b0001, 6'b100100}, // R6
        {16'hC000, 4'b0001, 6'b010000}, // R6
        {16'hE000, 4'b0001, 6'b010000}, // R6
        {16'h8000, 4'b1001, 6'b101000}, // R7
        {16'hA000, 4'b1001, 6'b010000}, // R7
        {16'hE000, 4'b1001, 6'b100100}, // R7
        {16'hFFFF, 4'b1001, 6'b100100}, // R7
        {16'hDE00, 4'b1001, 6'b100010}, // R8
        {16'hDE00, 4'b0111, 6'b010000}, // R9
        {16'hDF80, 4'b0011, 6'b010000}, // R9
        {16'h8000, 4'b0011, 6'b101000}, // R9
        {16'hDDFF, 4'b0101, 6'b010000}, // R8
        {16'h8000, 4'b0000, 6'b000000}  // R3
    };

    function automatic logic [5:0] outs();
        return {cart_sel, int_sel, roml, romh, io1, io2};
    endfunction

    task automatic check(input string req, input logic [5:0] exp);
        n_chk++;
        if (outs() !== exp) begin
            n_err++;
            $display("FAIL %s: got %b expected %b (addr=%h)", req, outs(), exp, addr);
        end
    endtask

    task automatic drive(input logic [15:0] a, input logic [3:0] c);
        addr = a; exrom_n = c[3]; game_n = c[2]; ovl_map = c[1]; acc_valid = c[0];
    endtask

    initial begin
        #200000;
        n_err++;
        $display("FAIL watchdog: got hung expected done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1;
        drive(16'h8000, 4'b0101);
        repeat (3) @(negedge clk);
        check("R1", 6'b000000);
        rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i][25:10], VEC[i][9:6]);
            @(negedge clk);
            check("R4-R9 table", VEC[i][5:0]);
            n_chk++;
            if (!$onehot0({roml, romh, io1, io2}) || (cart_sel != (roml | romh | io1 | io2))) begin
                n_err++;
                $display("FAIL R10: got %b expected at most one strobe", outs());
            end
        end
        // R2: output holds until the edge after new inputs
        @(negedge clk);
        drive(16'hA000, 4'b0101);
        @(negedge clk);
        check("R2", 6'b010000);
        drive(16'h8000, 4'b0101);
        #1;
        check("R2", 6'b010000);
        @(negedge clk);
        check("R2", 6'b101000);
        // R1: reset mid-run clears outputs
        rst = 1'b1;
        @(negedge clk);
        check("R1", 6'b000000);
        rst = 1'b0;
        @(negedge clk);
        check("R5", 6'b101000);
        // R3: idle with a cart address
        drive(16'hDE00, 4'b0100);
        @(negedge clk);
        check("R3", 6'b000000);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule